// File: doc/BRIEF.md
# Split-Read Timestamp Counter

This block is a free-running 64-bit cycle counter that a 32-bit processor reads as two data words. It does not freeze the count when one half is read. A small readout tracker follows the order of register accesses instead. It reports in a status bit whether the low and high words just fetched belong to the same 64-bit value. Software reads the low word, then the high word, then the control word. It repeats the three reads until the status bit comes back set.

The tracker spoils a pending pair in two cases. The first is an exception or interrupt taken between the low-word read and the high-word read. The second is a carry from the low word into the high word after the low word was sampled. Writing either counter word reloads that half and abandons any pending pair. Bit 0 of the control word starts and stops the count.

Top module: `tsc_split_read`

## Requirements
- R1: After a synchronous active-low reset, both counter words are 0, the count is enabled, and the control word reads 0x00000001 (status clear, enable set).
- R2: While enabled, and in a cycle with no write to a counter word, the low word (address 0) advances by one on every clock. A read of address 0 returns the value held in that cycle.
- R3: The high word (address 1) advances by one in exactly the cycle in which the low word rolls from 0xFFFFFFFF to 0. A read of address 1 returns the value held in that cycle.
- R4: Control bit 0 (address 2) is a read/write count enable, and the other written bits are ignored. While it is 0, both counter words hold their values.
- R5: A write to address 0 or 1 loads that word from the write data. In that cycle the other word keeps its value and neither word counts. The write also discards any pending pair, so the next control read shows status 0.
- R6: Address 3 reads as 0, and writes to it change nothing. The status flag sits at control bit 31, and bits 30..1 read 0.
- R7: Three reads in order (low, high, control) with no exception and no carry in between return status 1. The two words then equal the counter value held in the low-read cycle.
- R8: An exception pulse in any cycle from the low-word read up to and including the high-word read makes the following control read return status 0.
- R9: A carry into the high word counts against the pair if it occurs in the low-read cycle or in any later cycle before the high-word read. A carry in the cycle of the high-word read itself does not spoil the pair.
- R10: A high-word read with no low-word read since the last control read, write or verdict gives status 0. A fresh low-word read re-arms the tracker and clears any earlier fault.
- R11: A control read returns the verdict for the latest pair and then sends the tracker back to idle, so an immediate second control read returns status 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Single-cycle register access strobe |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 2 | Register select: 0 low word, 1 high word, 2 control, 3 unused |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| exc_taken | input | 1 | Pulse marking an exception or interrupt taken by the processor |

## Verification
The hardest case to reach is a carry out of the low word that lands exactly on the boundary between the low read and the high read. If it lands in the low-read cycle, the pair must be spoiled. If it lands in the high-read cycle, the pair must stay clean. With a free-running count this needs 2^32 cycles unless the low word is preloaded. The stimulus therefore writes the low word to values a few counts below 0xFFFFFFFF and then places the low and high reads at chosen offsets, both in directed cases and in random runs biased toward such preloads. Exception pulses are placed on the low-read cycle, on idle cycles in between, on the high-read cycle and after it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // Register select values; the bench and software depend on this map.
   typedef enum logic [1:0] {
      REG_LO    = 2'd0,
      REG_HI    = 2'd1,
      REG_CTL   = 2'd2,
      REG_SPARE = 2'd3
   } tsc_reg_e;

   typedef enum logic [1:0] {
      TRK_IDLE    = 2'd0,
      TRK_ARMED   = 2'd1,
      TRK_CLEAN   = 2'd2,
      TRK_SPOILED = 2'd3
   } trk_state_e;

   typedef struct packed {
      logic rd_lo;
      logic rd_hi;
      logic rd_ctl;
      logic wr_lo;
      logic wr_hi;
      logic wr_ctl;
   } tsc_access_t;

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int unsigned WORD_W       = 32,
   parameter bit          SPLIT_CARRY  = 1'b1,
   parameter bit          RESET_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_ctl,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word_lo,
   output logic [WORD_W-1:0] word_hi,
   output logic              run_en,
   output logic              wrap
);

   localparam int unsigned CNT_W = 2 * WORD_W;

   logic step;

   if (WORD_W < 2) begin : g_bad_width
      $error("tsc_counter: WORD_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en <= RESET_ENABLE;
      end else if (wr_ctl) begin
         run_en <= wdata[0];
      end
   end

   assign step = run_en && !wr_lo && !wr_hi;
   assign wrap = step && (word_lo == {WORD_W{1'b1}});

   if (SPLIT_CARRY) begin : g_split
      logic [WORD_W-1:0] lo_q;
      logic [WORD_W-1:0] hi_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
         end else if (wr_lo) begin
            lo_q <= wdata;
         end else if (step) begin
            lo_q <= lo_q + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
         end else if (wr_hi) begin
            hi_q <= wdata;
         end else if (wrap) begin
            hi_q <= hi_q + 1'b1;
         end
      end

      assign word_lo = lo_q;
      assign word_hi = hi_q;
   end else begin : g_wide
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (wr_lo) begin
            cnt_q <= {cnt_q[CNT_W-1:WORD_W], wdata};
         end else if (wr_hi) begin
            cnt_q <= {wdata, cnt_q[WORD_W-1:0]};
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign word_lo = cnt_q[WORD_W-1:0];
      assign word_hi = cnt_q[CNT_W-1:WORD_W];
   end

endmodule

// File: rtl/tsc_reg_decode.sv
module tsc_reg_decode
   import tsc_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_addr,
   input  logic [WORD_W-1:0] word_lo,
   input  logic [WORD_W-1:0] word_hi,
   input  logic              run_en,
   input  logic              pair_ok,
   output tsc_access_t       acc,
   output logic [WORD_W-1:0] rdata
);

   localparam int unsigned STATUS_BIT = WORD_W - 1;

   logic rd;
   logic wr;

   if (WORD_W < 2) begin : g_bad_width
      $error("tsc_reg_decode: WORD_W must be at least 2");
   end

   assign rd = acc_valid && !acc_write;
   assign wr = acc_valid && acc_write;

   always_comb begin
      acc        = '0;
      acc.rd_lo  = rd && (acc_addr == REG_LO);
      acc.rd_hi  = rd && (acc_addr == REG_HI);
      acc.rd_ctl = rd && (acc_addr == REG_CTL);
      acc.wr_lo  = wr && (acc_addr == REG_LO);
      acc.wr_hi  = wr && (acc_addr == REG_HI);
      acc.wr_ctl = wr && (acc_addr == REG_CTL);
   end

   always_comb begin
      rdata = '0;
      if (acc.rd_lo) begin
         rdata = word_lo;
      end else if (acc.rd_hi) begin
         rdata = word_hi;
      end else if (acc.rd_ctl) begin
         rdata[0]          = run_en;
         rdata[STATUS_BIT] = pair_ok;
      end
   end

endmodule

// File: rtl/tsc_read_tracker.sv
module tsc_read_tracker
   import tsc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  tsc_access_t acc,
   input  logic        exc_taken,
   input  logic        wrap,
   output logic        pair_ok
);

   trk_state_e state_q;
   trk_state_e state_d;
   logic       spoil;

   // Either event spoils a pair that has been started but not finished.
   assign spoil = exc_taken || wrap;

   always_comb begin
      state_d = state_q;
      if (acc.wr_lo || acc.wr_hi) begin
         state_d = TRK_IDLE;
      end else if (acc.rd_lo) begin
         state_d = spoil ? TRK_SPOILED : TRK_ARMED;
      end else if (acc.rd_hi) begin
         unique case (state_q)
            TRK_ARMED:   state_d = exc_taken ? TRK_SPOILED : TRK_CLEAN;
            TRK_SPOILED: state_d = TRK_SPOILED;
            default:     state_d = TRK_IDLE;
         endcase
      end else if (acc.rd_ctl) begin
         state_d = TRK_IDLE;
      end else if ((state_q == TRK_ARMED) && spoil) begin
         state_d = TRK_SPOILED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TRK_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign pair_ok = (state_q == TRK_CLEAN);

endmodule

// File: rtl/tsc_split_read.sv
module tsc_split_read
   import tsc_pkg::*;
#(
   parameter int unsigned WORD_W       = 32,
   parameter bit          SPLIT_CARRY  = 1'b1,
   parameter bit          RESET_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_addr,
   input  logic [WORD_W-1:0] acc_wdata,
   output logic [WORD_W-1:0] acc_rdata,
   input  logic              exc_taken
);

   tsc_access_t       acc;
   logic [WORD_W-1:0] cnt_lo;
   logic [WORD_W-1:0] cnt_hi;
   logic              cnt_run;
   logic              cnt_wrap;
   logic              pair_ok;

   tsc_reg_decode #(.WORD_W(WORD_W)) u_decode (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .word_lo   (cnt_lo),
      .word_hi   (cnt_hi),
      .run_en    (cnt_run),
      .pair_ok   (pair_ok),
      .acc       (acc),
      .rdata     (acc_rdata)
   );

   tsc_counter #(
      .WORD_W       (WORD_W),
      .SPLIT_CARRY  (SPLIT_CARRY),
      .RESET_ENABLE (RESET_ENABLE)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (acc.wr_lo),
      .wr_hi   (acc.wr_hi),
      .wr_ctl  (acc.wr_ctl),
      .wdata   (acc_wdata),
      .word_lo (cnt_lo),
      .word_hi (cnt_hi),
      .run_en  (cnt_run),
      .wrap    (cnt_wrap)
   );

   tsc_read_tracker u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .exc_taken (exc_taken),
      .wrap      (cnt_wrap),
      .pair_ok   (pair_ok)
   );

endmodule

// File: rtl/tsc_split_read_chk.sv
module tsc_split_read_chk #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [1:0]        acc_addr,
   input logic [WORD_W-1:0] acc_wdata,
   input logic              exc_taken,
   input logic [WORD_W-1:0] cnt_lo,
   input logic [WORD_W-1:0] cnt_hi,
   input logic              cnt_run,
   input logic              pair_ok
);

   logic cnt_wr;
   logic lo_wr;
   logic hi_rd;
   logic ctl_rd;

   assign cnt_wr = acc_valid && acc_write && (acc_addr[1] == 1'b0);
   assign lo_wr  = acc_valid && acc_write && (acc_addr == 2'd0);
   assign hi_rd  = acc_valid && !acc_write && (acc_addr == 2'd1);
   assign ctl_rd = acc_valid && !acc_write && (acc_addr == 2'd2);

   // R2
   lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_run && !cnt_wr && (cnt_lo != {WORD_W{1'b1}}))
      |=> (cnt_lo == $past(cnt_lo) + 1'b1));

   // R3
   hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_run && !cnt_wr && (cnt_lo == {WORD_W{1'b1}}))
      |=> ((cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + 1'b1)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_run && !cnt_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   // R5
   lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> ((cnt_lo == $past(acc_wdata)) && $stable(cnt_hi)));

   // R7
   clean_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_ok) |-> $past(hi_rd));

   // R8
   exc_spoil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && exc_taken) |=> !pair_ok);

   // R11
   ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |=> !pair_ok);

endmodule

bind tsc_split_read tsc_split_read_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .exc_taken (exc_taken),
   .cnt_lo    (cnt_lo),
   .cnt_hi    (cnt_hi),
   .cnt_run   (cnt_run),
   .pair_ok   (pair_ok)
);

// File: tb/tsc_split_read_test.sv
module tsc_split_read_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  acc_addr = 2'd0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        exc_taken = 1'b0;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          done     = 1'b0;

   // Bench reference state
   logic [63:0] m_cnt;
   bit          m_en;
   bit          m_armed;
   bit          m_exc_seen;
   logic [31:0] m_hi_snap;
   bit          m_verdict;

   always #2 clk = ~clk;   // 250 MHz

   tsc_split_read uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata),
      .exc_taken (exc_taken)
   );

   function automatic logic [31:0] exp_read(logic [1:0] a);
      case (a)
         2'd0:    return m_cnt[31:0];
         2'd1:    return m_cnt[63:32];
         2'd2:    return {m_verdict, 30'b0, m_en};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next falling edge.
   task automatic step(bit v, bit w, logic [1:0] a, logic [31:0] d, bit e, string tag);
      logic [31:0] exp;
      logic [31:0] hi_now;
      bit          taken;
      acc_valid = v;
      acc_write = w;
      acc_addr  = a;
      acc_wdata = d;
      exc_taken = e;
      #1;
      if (v && !w) begin
         exp = exp_read(a);
         check(acc_rdata === exp, tag, acc_rdata, exp);
      end
      @(posedge clk);
      hi_now = m_cnt[63:32];
      taken  = 1'b0;
      // pairing rules
      if (v && w && (a < 2'd2)) begin
         m_armed = 0; m_verdict = 0; taken = 1'b1;
      end else if (v && !w && a == 2'd0) begin
         m_armed = 1; m_exc_seen = e; m_hi_snap = hi_now; m_verdict = 0; taken = 1'b1;
      end else if (v && !w && a == 2'd1) begin
         m_verdict = m_armed && !(m_exc_seen || e) && (m_hi_snap == hi_now);
         m_armed = 0; taken = 1'b1;
      end else if (v && !w && a == 2'd2) begin
         m_verdict = 0; m_armed = 0; taken = 1'b1;
      end
      if (!taken && m_armed && e) m_exc_seen = 1;
      // counter rules
      if (v && w && a == 2'd0)      m_cnt[31:0]  = d;
      else if (v && w && a == 2'd1) m_cnt[63:32] = d;
      else if (m_en)                m_cnt = m_cnt + 64'd1;
      if (v && w && a == 2'd2)      m_en = d[0];
      @(negedge clk);
      acc_valid = 1'b0;
      exc_taken = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, bit e, string tag);
      step(1'b1, 1'b0, a, 32'h0, e, tag);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
      step(1'b1, 1'b1, a, d, 1'b0, tag);
   endtask

   task automatic idle(bit e);
      step(1'b0, 1'b0, 2'd0, 32'h0, e, "idle");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20161031));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = '0; m_en = 1; m_armed = 0; m_exc_seen = 0; m_hi_snap = '0; m_verdict = 0;

      // R1 reset state
      rd(2'd0, 0, "R1 low after reset");
      rd(2'd2, 0, "R1 control after reset");
      rd(2'd1, 0, "R1 high after reset");

      // R2 counting
      rd(2'd0, 0, "R2 low step");
      idle(0); idle(0);
      rd(2'd0, 0, "R2 low step after idles");

      // R4 enable off then on; stray bits ignored
      wr(2'd2, 32'hFFFF_FFFE, "R4 disable");
      rd(2'd2, 0, "R4 control shows disabled");
      rd(2'd0, 0, "R4 low holds");
      idle(0);
      rd(2'd0, 0, "R4 low still holds");
      wr(2'd2, 32'h0000_0001, "R4 enable");
      idle(0);
      rd(2'd0, 0, "R4 low resumes");

      // R6 spare address
      rd(2'd3, 0, "R6 spare reads zero");
      wr(2'd3, 32'hDEAD_BEEF, "R6 spare write");
      rd(2'd2, 0, "R6 control unaffected by spare write");

      // R7 clean sequence
      rd(2'd0, 0, "R7 low");
      rd(2'd1, 0, "R7 high");
      rd(2'd2, 0, "R7 verdict clean");
      // R11 second control read
      rd(2'd2, 0, "R11 second control read clear");

      // R5 loads and discard of pending pair
      wr(2'd1, 32'h0000_1234, "R5 load high");
      rd(2'd1, 0, "R5 high loaded");
      rd(2'd0, 0, "R5 low");
      wr(2'd0, 32'h0000_0100, "R5 load low mid pair");
      rd(2'd1, 0, "R5 high after load");
      rd(2'd2, 0, "R5 verdict after load");
      rd(2'd0, 0, "R5 low loaded");

      // R3 carry into high word
      wr(2'd0, 32'hFFFF_FFFF, "R3 preload");
      idle(0);
      rd(2'd1, 0, "R3 high incremented");
      rd(2'd0, 0, "R3 low wrapped");

      // R9 carry in low-read cycle spoils
      wr(2'd0, 32'hFFFF_FFFF, "R9 preload a");
      rd(2'd0, 0, "R9 low at max");
      rd(2'd1, 0, "R9 high after carry");
      rd(2'd2, 0, "R9 verdict spoiled by carry in low cycle");
      // R9 carry in idle cycle between spoils
      wr(2'd0, 32'hFFFF_FFFE, "R9 preload b");
      rd(2'd0, 0, "R9 low");
      idle(0);
      rd(2'd1, 0, "R9 high");
      rd(2'd2, 0, "R9 verdict spoiled by carry between");
      // R9 carry in high-read cycle keeps pair clean
      wr(2'd0, 32'hFFFF_FFFE, "R9 preload c");
      rd(2'd0, 0, "R9 low");
      rd(2'd1, 0, "R9 high");
      rd(2'd2, 0, "R9 verdict clean, carry on high cycle");

      // R8 exception placement
      rd(2'd0, 1, "R8 low with exception");
      rd(2'd1, 0, "R8 high");
      rd(2'd2, 0, "R8 verdict spoiled, exception on low cycle");
      rd(2'd0, 0, "R8 low");
      idle(1);
      rd(2'd1, 0, "R8 high");
      rd(2'd2, 0, "R8 verdict spoiled, exception between");
      rd(2'd0, 0, "R8 low");
      rd(2'd1, 1, "R8 high with exception");
      rd(2'd2, 0, "R8 verdict spoiled, exception on high cycle");
      rd(2'd0, 0, "R8 low");
      rd(2'd1, 0, "R8 high");
      idle(1);
      rd(2'd2, 0, "R8 verdict clean, exception after high");

      // R10 unarmed high read, re-arm after fault
      rd(2'd1, 0, "R10 high alone");
      rd(2'd2, 0, "R10 verdict unarmed");
      rd(2'd0, 1, "R10 low faulted");
      rd(2'd0, 0, "R10 low re-arm");
      rd(2'd1, 0, "R10 high");
      rd(2'd2, 0, "R10 verdict after re-arm");

      // Constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned pick = $urandom_range(0, 99);
         bit          e    = ($urandom_range(0, 19) == 0);
         if (pick < 6) begin
            wr(2'd0, 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)), "R5 random low load");
         end else if (pick < 8) begin
            wr(2'd1, $urandom, "R5 random high load");
         end else if (pick < 10) begin
            wr(2'd2, ($urandom_range(0, 7) == 0) ? 32'h0 : 32'h1, "R4 random enable");
         end else if (pick < 11) begin
            wr(2'd3, $urandom, "R6 random spare write");
         end else if (pick < 36) begin
            rd(2'd0, e, "R2 random low read");
         end else if (pick < 61) begin
            rd(2'd1, e, "R3 random high read");
         end else if (pick < 81) begin
            rd(2'd2, e, "R7 random control read");
         end else if (pick < 83) begin
            rd(2'd3, e, "R6 random spare read");
         end else begin
            idle(e);
         end
      end

      finish_run();
   end

endmodule